// File: doc/BRIEF.md
# Boost Converter Soft-Start Sequencer

This block steers a synchronous boost converter from enable to regulation. It runs in three steps. First the rectifying switch charges the output capacitor with a limited current. Next the converter switches at a fixed, open-loop duty cycle while the output is still low. Last, the closed-loop current-mode controller takes over. Three comparator flags move it from one step to the next: the output has reached about 90 % of the battery, the output is above the 2.3 V knee, and the output is within 3 % of target. When the last flag rises, the block raises a done flag.

The block also produces the inductor peak-current-limit code. This code starts at a low value and climbs by one on each ramp tick while the converter switches, so inrush current stays bounded. It stops at full scale, code 15, which stands for about 1.3 A. During the fixed-duty step, a counter of switching periods forms a gate that is high for three periods out of every four, which gives 75 % duty. This stays below the 87.5 % ceiling of normal operation.

All pins are plain level or pulse signals. No data stream passes through the block, so no port has a handshake. Dropping enable stops the sequence from any step.

Top module: `boost_softstart_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, phase is 0 (idle). In that state linear_on, fixed_gate, loop_on and done are all 0, and ilim_code is 0.
- R2: In idle, with enable high, the block moves to the pre-charge step on the next clock edge. The phase code is 1 and linear_on is 1. On that same edge ilim_code loads its minimum value, 4.
- R3: The pre-charge step lasts until out_precharged is seen high. In that step the knee flag, the in-window flag and ramp ticks change neither the phase nor ilim_code.
- R4: When out_precharged is high in pre-charge, the next edge moves the block to the fixed-duty step (phase code 2). On entry, fixed_gate is 1. It stays 1 for the first three period_tick pulses, drops to 0 after the third, and returns to 1 after the fourth. Between pulses it holds its value.
- R5: When out_above_knee is high in the fixed-duty step, the next edge moves the block to closed loop (phase code 3). There loop_on is 1, while fixed_gate and linear_on are 0.
- R6: When out_in_window is high in closed loop, done rises on the next edge. It then stays high, with phase 3 and loop_on 1, for as long as enable stays high, even after out_in_window falls.
- R7: In the fixed-duty and closed-loop steps, each ramp_tick pulse raises ilim_code by one. The code holds at 15 and never goes higher.
- R8: If enable is low at any clock edge, that edge returns the block to idle. It clears ilim_code to 0, and turns done and all phase outputs off. Enabling again starts a new sequence from pre-charge.
- R9: At most one of linear_on, the fixed-duty step and loop_on is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Start request; low forces idle |
| out_precharged | input | 1 | Output has reached about 90 % of battery |
| out_above_knee | input | 1 | Output is above the 2.3 V knee |
| out_in_window | input | 1 | Output is within 3 % of target |
| ramp_tick | input | 1 | One-cycle pulse that advances the current-limit ramp |
| period_tick | input | 1 | One-cycle pulse at each switching-period start |
| phase | output | 2 | 0 idle, 1 pre-charge, 2 fixed duty, 3 closed loop |
| linear_on | output | 1 | Rectifier conducts in current-limited pre-charge |
| fixed_gate | output | 1 | Open-loop low-side gate request in the fixed-duty step |
| loop_on | output | 1 | Closed-loop current-mode control active |
| ilim_code | output | 4 | Peak-current-limit code, 15 is full scale |
| done | output | 1 | Soft-start finished |

## Verification
The sequence is run forward with each comparator flag raised only in its own step. Flags are also raised too early: the knee and in-window flags during pre-charge. This shows whether steps advance in order or can be skipped. Groups of ramp ticks are sent in pre-charge, in fixed duty, and past full scale. This tells a held code apart from a counting code and from one that wraps. Period ticks are sent one at a time, so the 3-of-4 gate pattern and its return to high are seen period by period. Enable is dropped both after done and in the middle of the fixed-duty step, and then the block is enabled again. This shows that it recovers fully from any step.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRECHG = 3'd1,
    ST_FIXED  = 3'd2,
    ST_CLOSED = 3'd3,
    ST_REGUL  = 3'd4
  } ss_state_e;

  localparam logic [1:0] PH_IDLE   = 2'd0;
  localparam logic [1:0] PH_PRECHG = 2'd1;
  localparam logic [1:0] PH_FIXED  = 2'd2;
  localparam logic [1:0] PH_CLOSED = 2'd3;
endpackage

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
  import ss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      out_precharged,
  input  logic      out_above_knee,
  input  logic      out_in_window,
  output ss_state_e state,
  output logic      start
);
  ss_state_e state_nx;

  assign start = (state == ST_IDLE) && enable;

  always_comb begin
    state_nx = state;
    if (!enable) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:   state_nx = ST_PRECHG;
        ST_PRECHG: if (out_precharged) state_nx = ST_FIXED;
        ST_FIXED:  if (out_above_knee) state_nx = ST_CLOSED;
        ST_CLOSED: if (out_in_window)  state_nx = ST_REGUL;
        ST_REGUL:  state_nx = ST_REGUL;
        default:   state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assert_idle_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> state == ST_IDLE);

  assert_precharge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRECHG && enable && !out_precharged) |=> state == ST_PRECHG);
endmodule

// File: rtl/ss_ilim_ramp.sv
module ss_ilim_ramp #(
  parameter int ILIM_W   = 4,
  parameter int ILIM_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic              run,
  input  logic              tick,
  output logic [ILIM_W-1:0] code
);
  localparam logic [ILIM_W-1:0] CODE_MAX = {ILIM_W{1'b1}};
  localparam logic [ILIM_W-1:0] CODE_MIN = ILIM_W'(ILIM_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            code <= '0;
    else if (!enable)                      code <= '0;
    else if (load)                         code <= CODE_MIN;
    else if (run && tick && code != CODE_MAX) code <= code + 1'b1;
  end

  assert_code_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && enable) |-> code >= $past(code));

  assert_code_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> code == '0);
endmodule

// File: rtl/ss_duty_gen.sv
module ss_duty_gen #(
  parameter int DUTY_PH = 4,
  parameter int DUTY_ON = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic period_tick,
  output logic gate
);
  localparam int CW = (DUTY_PH > 1) ? $clog2(DUTY_PH) : 1;
  localparam logic [CW-1:0] LAST = CW'(DUTY_PH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!active)     cnt <= '0;
    else if (period_tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  generate
    if (DUTY_ON >= DUTY_PH) begin : g_full
      assign gate = active;
    end else begin : g_part
      assign gate = active && (int'(cnt) < DUTY_ON);
    end
  endgenerate

  assert_gate_recovers_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(period_tick) && !$past(gate)) |-> gate);

  assert_gate_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(period_tick)) |-> $stable(gate));
endmodule

// File: rtl/boost_softstart_seq.sv
module boost_softstart_seq
  import ss_pkg::*;
#(
  parameter int ILIM_W   = 4,
  parameter int ILIM_MIN = 4,
  parameter int DUTY_PH  = 4,
  parameter int DUTY_ON  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              out_precharged,
  input  logic              out_above_knee,
  input  logic              out_in_window,
  input  logic              ramp_tick,
  input  logic              period_tick,
  output logic [1:0]        phase,
  output logic              linear_on,
  output logic              fixed_gate,
  output logic              loop_on,
  output logic [ILIM_W-1:0] ilim_code,
  output logic              done
);
  ss_state_e state;
  logic      start;
  logic      in_fixed;
  logic      boosting;

  ss_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .out_precharged(out_precharged), .out_above_knee(out_above_knee),
    .out_in_window(out_in_window), .state(state), .start(start)
  );

  assign in_fixed  = (state == ST_FIXED);
  assign linear_on = (state == ST_PRECHG);
  assign loop_on   = (state == ST_CLOSED) || (state == ST_REGUL);
  assign done      = (state == ST_REGUL);
  assign boosting  = in_fixed || loop_on;

  always_comb begin
    unique case (state)
      ST_PRECHG:          phase = PH_PRECHG;
      ST_FIXED:           phase = PH_FIXED;
      ST_CLOSED, ST_REGUL: phase = PH_CLOSED;
      default:            phase = PH_IDLE;
    endcase
  end

  ss_ilim_ramp #(.ILIM_W(ILIM_W), .ILIM_MIN(ILIM_MIN)) u_ramp (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(start),
    .run(boosting), .tick(ramp_tick), .code(ilim_code)
  );

  ss_duty_gen #(.DUTY_PH(DUTY_PH), .DUTY_ON(DUTY_ON)) u_duty (
    .clk(clk), .rst_n(rst_n), .active(in_fixed),
    .period_tick(period_tick), .gate(fixed_gate)
  );

  assert_single_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({linear_on, in_fixed, loop_on}));

  assert_done_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> done);

  assert_gate_only_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> !fixed_gate);
endmodule

// File: tb/boost_softstart_seq_bench.sv
module boost_softstart_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       out_precharged = 1'b0;
  logic       out_above_knee = 1'b0;
  logic       out_in_window = 1'b0;
  logic       ramp_tick = 1'b0;
  logic       period_tick = 1'b0;
  logic [1:0] phase;
  logic       linear_on, fixed_gate, loop_on, done;
  logic [3:0] ilim_code;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  boost_softstart_seq u_boost_softstart_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .out_precharged(out_precharged), .out_above_knee(out_above_knee),
    .out_in_window(out_in_window), .ramp_tick(ramp_tick),
    .period_tick(period_tick), .phase(phase), .linear_on(linear_on),
    .fixed_gate(fixed_gate), .loop_on(loop_on), .ilim_code(ilim_code),
    .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ramp(input int n);
    for (int i = 0; i < n; i++) begin
      ramp_tick = 1'b1; step(); ramp_tick = 1'b0; step();
    end
  endtask

  task automatic pulse_period;
    period_tick = 1'b1; step(); period_tick = 1'b0;
  endtask

  task automatic check_outs(input string req, input int ph, input int lin,
                            input int gate, input int lp, input int code, input int dn);
    check(req, "phase", phase, ph);
    check(req, "linear_on", linear_on, lin);
    check(req, "fixed_gate", fixed_gate, gate);
    check(req, "loop_on", loop_on, lp);
    check(req, "ilim_code", ilim_code, code);
    check(req, "done", done, dn);
  endtask

  task automatic t_reset;
    step(2);
    check_outs("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    step();
    check_outs("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_precharge;
    enable = 1'b1;
    step();
    check_outs("R2", 1, 1, 0, 0, 4, 0);
    step(4);
    check("R3", "phase waits for flag", phase, 1);
    out_above_knee = 1'b1; out_in_window = 1'b1;
    step(2);
    check("R3", "phase ignores later flags", phase, 1);
    pulse_ramp(3);
    check("R3", "code held in pre-charge", ilim_code, 4);
    out_above_knee = 1'b0; out_in_window = 1'b0;
  endtask

  task automatic t_fixed;
    out_precharged = 1'b1;
    step();
    out_precharged = 1'b0;
    check_outs("R4", 2, 0, 1, 0, 4, 0);
    pulse_period(); check("R4", "gate after tick 1", fixed_gate, 1);
    pulse_period(); check("R4", "gate after tick 2", fixed_gate, 1);
    pulse_period(); check("R4", "gate after tick 3", fixed_gate, 0);
    step(3);        check("R4", "gate held low between ticks", fixed_gate, 0);
    pulse_period(); check("R4", "gate after tick 4", fixed_gate, 1);
    pulse_ramp(3);
    check("R7", "code counts in fixed duty", ilim_code, 7);
  endtask

  task automatic t_closed;
    out_above_knee = 1'b1;
    step();
    check_outs("R5", 3, 0, 0, 1, 7, 0);
    pulse_period();
    check("R5", "no gate in closed loop", fixed_gate, 0);
    pulse_ramp(8);
    check("R7", "code reaches full scale", ilim_code, 15);
    pulse_ramp(2);
    check("R7", "code saturates", ilim_code, 15);
  endtask

  task automatic t_done;
    out_in_window = 1'b1;
    step();
    check_outs("R6", 3, 0, 0, 1, 15, 1);
    out_in_window = 1'b0; out_above_knee = 1'b0;
    step(5);
    check_outs("R6", 3, 0, 0, 1, 15, 1);
  endtask

  task automatic t_disable;
    enable = 1'b0;
    step();
    check_outs("R8", 0, 0, 0, 0, 0, 0);
    enable = 1'b1;
    step();
    check_outs("R8", 1, 1, 0, 0, 4, 0);
    out_precharged = 1'b1; step(); out_precharged = 1'b0;
    pulse_ramp(2);
    check("R8", "mid fixed code", ilim_code, 6);
    enable = 1'b0;
    step();
    check_outs("R8", 0, 0, 0, 0, 0, 0);
    pulse_ramp(2);
    check("R8", "idle ignores ticks", ilim_code, 0);
  endtask

  initial begin
    t_reset();
    t_precharge();
    t_fixed();
    t_closed();
    t_done();
    t_disable();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule